// File: doc/BRIEF.md
# FTN Matched-Filter Symbol Reconstructor

This receiver block estimates every faster-than-Nyquist symbol from the real-valued samples that the OQAM demodulator places on the orthogonal time-frequency grid. Each FTN symbol was spread by the transmitter over a 3 by 3 patch of orthogonal positions (three time columns by three sub-carriers), with weights that depend on the chosen time-frequency compression. The block applies the transpose of that spreading. For each symbol it correlates the nine received projections around the symbol with the same pre-computed weights and emits one soft value. That value holds the symbol's own energy plus the interference that its neighbours still contribute.

Samples arrive one at a time, column by column, sub-carrier 0 first. A frame holds `NT` columns of `NF` samples each. A four-column ring buffer keeps the patch of every symbol available. A single multiply-accumulate unit spends nine cycles on each estimate, then rounds and saturates the result. Several weight sets are held as a parameter table, and the first sample of each frame picks the set for that frame.

Top module: `ftnmf_recon`

## Requirements
- R1: While reset is held and after it is released, `est_valid` stays low until samples arrive. After a frame's first column alone has been received, no estimate appears.
- R2: The estimate for sub-carrier m, column n equals the rounded, saturated sum over tap j = 3*(dt+1)+(df+1), where dt and df each range over -1, 0 and +1, of W[s][j] * x[n+dt][m+df]. The weight W[s][j] is the signed `CW`-bit field at bits `(s*9+j)*CW` of `COEF_TABLE`.
- R3: Neighbour positions at sub-carrier -1 or `NF` lie outside the grid and count as zero.
- R4: Neighbour columns -1 and `NT` of a frame count as zero. No sample of an adjacent frame enters an estimate.
- R5: With rounding enabled, the output is floor((sum + 2^(SH-1)) / 2^SH), which rounds half toward plus infinity.
- R6: Results above 2^(OW-1)-1 or below -2^(OW-1) are clamped to those limits.
- R7: Estimates leave one per pulse of `est_valid`, never in two consecutive cycles. They come column by column and, within a column, by ascending sub-carrier. `est_row` and `est_col` carry the position.
- R8: The weight set is the value of `in_cset` presented with the frame's first sample. Changes on `in_cset` later in the frame have no effect. Codes at or above `NSET` select set 0.
- R9: The estimates of column n are not emitted before column n+1 of the same frame has been completely received. For the last column, the wait is only for that column itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A received sample is presented this cycle |
| in_data | input | SW | Signed received projection |
| in_cset | input | CSW | Weight-set code, taken with a frame's first sample |
| est_valid | output | 1 | An estimate is presented this cycle |
| est_data | output | OW | Signed soft estimate |
| est_row | output | RW | Sub-carrier index of the estimate |
| est_col | output | CLW | Column index of the estimate within its frame |

## Verification
The estimate for sub-carrier m of column n appears 11 + 9*m cycles after the clock edge that stores the last sample of column n+1. For a frame's last column, the reference edge is the one that stores that column's own final sample. Because the result's cycle is fixed by the arrival of a later column rather than by the symbol's own samples, the scoreboard pairs results with expectations by order and position tags. It samples on the falling edge of every cycle in which `est_valid` is high. A companion property confirms that no result ever precedes the column it depends on. A quiet window after the first column confirms that the wait really happens.

// File: rtl/ftnmf_pkg.sv
package ftnmf_pkg;
   // Ring of column slots: three for the patch plus one being filled.
   localparam int NSLOT = 4;
   localparam int SLW   = 2;
   localparam int TAPS  = 9;

   // Time offset index (0,1,2 for -1,0,+1) of a tap number 0..8.
   function automatic logic [1:0] tap_time(input logic [3:0] tap);
      if (tap >= 4'd6)      return 2'd2;
      else if (tap >= 4'd3) return 2'd1;
      else                  return 2'd0;
   endfunction
endpackage

// File: rtl/ftnmf_grid_buf.sv
module ftnmf_grid_buf
   import ftnmf_pkg::*;
#(
   parameter int NF  = 8,
   parameter int NT  = 6,
   parameter int SW  = 10,
   parameter int CSW = 1,
   parameter int RW  = 3,
   parameter int CLW = 3
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   input  logic [SW-1:0]  in_data,
   input  logic [CSW-1:0] in_cset,
   output logic           col_done,
   input  logic [SLW-1:0] rd_slot,
   input  logic [RW-1:0]  rd_row,
   output logic [SW-1:0]  rd_data,
   input  logic [SLW-1:0] tag_slot,
   output logic [CSW-1:0] tag_cset
);
   localparam int DEPTH = NSLOT * NF;
   localparam int AW    = $clog2(DEPTH);

   logic [SW-1:0]  mem [DEPTH];
   logic [CSW-1:0] slot_cset [NSLOT];
   logic [RW-1:0]  wr_row;
   logic [CLW-1:0] wr_col;
   logic [SLW-1:0] wr_slot;
   logic [CSW-1:0] frame_cset;
   logic [AW-1:0]  wr_addr, rd_addr;
   logic           first_of_frame;

   // Address mapping: plain concatenation when NF is a power of two,
   // a multiply otherwise.
   generate
      if ((1 << RW) == NF) begin : g_pow2
         assign wr_addr = {wr_slot, wr_row};
         assign rd_addr = {rd_slot, rd_row};
      end else begin : g_mult
         assign wr_addr = AW'(int'(wr_slot) * NF + int'(wr_row));
         assign rd_addr = AW'(int'(rd_slot) * NF + int'(rd_row));
      end
   endgenerate

   assign first_of_frame = (wr_row == '0) && (wr_col == '0);

   always_ff @(posedge clk) begin
      if (in_valid) mem[wr_addr] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_row     <= '0;
         wr_col     <= '0;
         wr_slot    <= '0;
         frame_cset <= '0;
         col_done   <= 1'b0;
         for (int i = 0; i < NSLOT; i++) slot_cset[i] <= '0;
      end else begin
         col_done <= in_valid && (wr_row == RW'(NF-1));
         if (in_valid) begin
            if (first_of_frame) frame_cset <= in_cset;
            if (wr_row == '0)
               slot_cset[wr_slot] <= first_of_frame ? in_cset : frame_cset;
            if (wr_row == RW'(NF-1)) begin
               wr_row  <= '0;
               wr_slot <= wr_slot + 1'b1;
               wr_col  <= (wr_col == CLW'(NT-1)) ? '0 : wr_col + 1'b1;
            end else begin
               wr_row <= wr_row + 1'b1;
            end
         end
      end
   end

   assign rd_data  = mem[rd_addr];
   assign tag_cset = slot_cset[tag_slot];
endmodule

// File: rtl/ftnmf_seq.sv
module ftnmf_seq
   import ftnmf_pkg::*;
#(
   parameter int NF  = 8,
   parameter int NT  = 6,
   parameter int RW  = 3,
   parameter int CLW = 3
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           col_done,
   output logic           tap_en,
   output logic           tap_first,
   output logic           tap_last,
   output logic           tap_zero,
   output logic [3:0]     tap,
   output logic [SLW-1:0] rd_slot,
   output logic [RW-1:0]  rd_row,
   output logic [SLW-1:0] ctr_slot,
   output logic [RW-1:0]  sym_row,
   output logic [CLW-1:0] sym_col
);
   logic           run;
   logic [SLW-1:0] e_slot;
   logic [CLW-1:0] e_col;
   logic [RW-1:0]  row;
   logic [2:0]     ahead;
   logic           start, retire;
   logic [1:0]     tap_t, tap_f;
   logic [RW:0]    rsum;

   always_comb begin
      tap_t = tap_time(tap);
      tap_f = 2'(tap - 4'(3 * int'(tap_t)));
   end

   assign retire = run && (tap == 4'd8) && (row == RW'(NF-1));
   assign start  = !run && ((ahead >= 3'd2) ||
                   ((ahead != 3'd0) && (e_col == CLW'(NT-1))));

   always_ff @(posedge clk) begin
      if (rst) begin
         run    <= 1'b0;
         e_slot <= '0;
         e_col  <= '0;
         row    <= '0;
         tap    <= '0;
         ahead  <= '0;
      end else begin
         ahead <= ahead + {2'b00, col_done} - {2'b00, retire};
         if (start) begin
            run <= 1'b1;
            row <= '0;
            tap <= '0;
         end else if (run) begin
            if (tap == 4'd8) begin
               tap <= '0;
               if (row == RW'(NF-1)) begin
                  run    <= 1'b0;
                  row    <= '0;
                  e_slot <= e_slot + 1'b1;
                  e_col  <= (e_col == CLW'(NT-1)) ? '0 : e_col + 1'b1;
               end else begin
                  row <= row + 1'b1;
               end
            end else begin
               tap <= tap + 1'b1;
            end
         end
      end
   end

   assign tap_zero = ((row == '0) && (tap_f == 2'd0)) ||
                     ((row == RW'(NF-1)) && (tap_f == 2'd2)) ||
                     ((e_col == '0) && (tap_t == 2'd0)) ||
                     ((e_col == CLW'(NT-1)) && (tap_t == 2'd2));
   assign rsum      = {1'b0, row} + (RW+1)'(tap_f);
   assign rd_row    = tap_zero ? '0 : RW'(rsum - 1'b1);
   assign rd_slot   = e_slot + SLW'(tap_t) + SLW'(NSLOT-1);
   assign ctr_slot  = e_slot;
   assign tap_en    = run;
   assign tap_first = run && (tap == 4'd0);
   assign tap_last  = run && (tap == 4'd8);
   assign sym_row   = row;
   assign sym_col   = e_col;
endmodule

// File: rtl/ftnmf_mac.sv
module ftnmf_mac #(
   parameter int SW       = 10,
   parameter int CW       = 12,
   parameter int OW       = 16,
   parameter int SH       = 4,
   parameter int ROUND_EN = 1,
   parameter int RW       = 3,
   parameter int CLW      = 3
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           tap_en,
   input  logic           tap_first,
   input  logic           tap_last,
   input  logic           tap_zero,
   input  logic [SW-1:0]  smp,
   input  logic [CW-1:0]  coef,
   input  logic [RW-1:0]  sym_row,
   input  logic [CLW-1:0] sym_col,
   output logic           est_valid,
   output logic [OW-1:0]  est_data,
   output logic [RW-1:0]  est_row,
   output logic [CLW-1:0] est_col
);
   localparam int AW = SW + CW + 4;
   localparam logic signed [AW-1:0] OMAX = AW'(2**(OW-1) - 1);
   localparam logic signed [AW-1:0] OMIN = -OMAX - AW'(1);

   logic signed [AW-1:0] acc, prod, total, scaled, clamped;

   assign prod  = tap_zero ? '0 : AW'($signed(smp)) * AW'($signed(coef));
   assign total = (tap_first ? '0 : acc) + prod;

   generate
      if (ROUND_EN != 0) begin : g_round
         localparam logic signed [AW-1:0] HALF = AW'(2**(SH-1));
         assign scaled = (total + HALF) >>> SH;
      end else begin : g_trunc
         assign scaled = total >>> SH;
      end
   endgenerate

   always_comb begin
      if (scaled > OMAX)      clamped = OMAX;
      else if (scaled < OMIN) clamped = OMIN;
      else                    clamped = scaled;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc       <= '0;
         est_valid <= 1'b0;
         est_data  <= '0;
         est_row   <= '0;
         est_col   <= '0;
      end else begin
         est_valid <= tap_last;
         if (tap_en) acc <= total;
         if (tap_last) begin
            est_data <= clamped[OW-1:0];
            est_row  <= sym_row;
            est_col  <= sym_col;
         end
      end
   end
endmodule

// File: rtl/ftnmf_recon.sv
module ftnmf_recon
   import ftnmf_pkg::*;
#(
   parameter int NF       = 8,
   parameter int NT       = 6,
   parameter int SW       = 10,
   parameter int CW       = 12,
   parameter int OW       = 16,
   parameter int SH       = 4,
   parameter int ROUND_EN = 1,
   parameter int NSET     = 2,
   parameter logic [NSET*9*CW-1:0] COEF_TABLE = {
      -12'sd120, 12'sd350, -12'sd120, 12'sd450, 12'sd1024, 12'sd450,
      -12'sd120, 12'sd350, -12'sd120,
      -12'sd60,  12'sd200, -12'sd60,  12'sd300, 12'sd1024, 12'sd300,
      -12'sd60,  12'sd200, -12'sd60},
   localparam int RW  = $clog2(NF),
   localparam int CLW = $clog2(NT),
   localparam int CSW = (NSET > 1) ? $clog2(NSET) : 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   input  logic [SW-1:0]  in_data,
   input  logic [CSW-1:0] in_cset,
   output logic           est_valid,
   output logic [OW-1:0]  est_data,
   output logic [RW-1:0]  est_row,
   output logic [CLW-1:0] est_col
);
   generate
      if (NF < 2)            begin : g_bad_nf   $error("NF must be at least 2");        end
      if (NT < 2)            begin : g_bad_nt   $error("NT must be at least 2");        end
      if (SH < 1)            begin : g_bad_sh   $error("SH must be at least 1");        end
      if (OW > 24 || OW < 2) begin : g_bad_ow   $error("OW must lie in 2..24");         end
      if (OW > SW + CW + 4)  begin : g_bad_acc  $error("OW exceeds accumulator width"); end
      if (NSET < 1)          begin : g_bad_set  $error("NSET must be at least 1");      end
   endgenerate

   logic           col_done, tap_en, tap_first, tap_last, tap_zero;
   logic [3:0]     tap;
   logic [SLW-1:0] rd_slot, ctr_slot;
   logic [RW-1:0]  rd_row, sym_row;
   logic [CLW-1:0] sym_col;
   logic [SW-1:0]  rd_data;
   logic [CSW-1:0] tag_cset, cs_eff;
   logic [CW-1:0]  coef;

   ftnmf_grid_buf #(.NF(NF), .NT(NT), .SW(SW), .CSW(CSW), .RW(RW), .CLW(CLW)) buf_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_cset(in_cset),
      .col_done(col_done), .rd_slot(rd_slot), .rd_row(rd_row), .rd_data(rd_data),
      .tag_slot(ctr_slot), .tag_cset(tag_cset));

   ftnmf_seq #(.NF(NF), .NT(NT), .RW(RW), .CLW(CLW)) seq_i (
      .clk(clk), .rst(rst), .col_done(col_done), .tap_en(tap_en), .tap_first(tap_first),
      .tap_last(tap_last), .tap_zero(tap_zero), .tap(tap), .rd_slot(rd_slot),
      .rd_row(rd_row), .ctr_slot(ctr_slot), .sym_row(sym_row), .sym_col(sym_col));

   assign cs_eff = (int'(tag_cset) < NSET) ? tag_cset : '0;
   assign coef   = COEF_TABLE[(int'(cs_eff) * TAPS + int'(tap)) * CW +: CW];

   ftnmf_mac #(.SW(SW), .CW(CW), .OW(OW), .SH(SH), .ROUND_EN(ROUND_EN),
               .RW(RW), .CLW(CLW)) mac_i (
      .clk(clk), .rst(rst), .tap_en(tap_en), .tap_first(tap_first), .tap_last(tap_last),
      .tap_zero(tap_zero), .smp(rd_data), .coef(coef), .sym_row(sym_row),
      .sym_col(sym_col), .est_valid(est_valid), .est_data(est_data),
      .est_row(est_row), .est_col(est_col));
endmodule

// File: rtl/ftnmf_recon_chk.sv
module ftnmf_recon_chk #(
   parameter int NF  = 8,
   parameter int NT  = 6,
   parameter int RW  = 3,
   parameter int CLW = 3
) (
   input logic           clk,
   input logic           rst,
   input logic           in_valid,
   input logic           est_valid,
   input logic [RW-1:0]  est_row,
   input logic [CLW-1:0] est_col
);
   logic          rst_q, seen;
   logic [RW-1:0] last_row, in_row;
   int unsigned   wcols, ecols;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
         seen     <= 1'b0;
         last_row <= '0;
         in_row   <= '0;
         wcols    <= 0;
         ecols    <= 0;
      end else begin
         if (in_valid) begin
            if (in_row == RW'(NF-1)) begin
               in_row <= '0;
               wcols  <= wcols + 1;
            end else begin
               in_row <= in_row + 1'b1;
            end
         end
         if (est_valid) begin
            seen     <= 1'b1;
            last_row <= est_row;
            if (est_row == RW'(NF-1)) ecols <= ecols + 1;
         end
      end
   end

   // R1: nothing is presented in the cycle after reset was held
   always_ff @(posedge clk) begin
      if (rst_q) a_r1_quiet_in_reset: assert (!est_valid) else $error("estimate during reset");
   end

   // R7: one estimate per pulse
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
      est_valid |=> !est_valid);

   // R7: sub-carrier order within and across columns
   a_r7_row_order: assert property (@(posedge clk) disable iff (rst)
      (est_valid && seen) |->
         (est_row == ((last_row == RW'(NF-1)) ? '0 : last_row + 1'b1)));

   // R9: a column is never estimated before its successor is in
   a_r9_no_early: assert property (@(posedge clk) disable iff (rst)
      est_valid |-> ((wcols >= ecols + 2) ||
                     ((est_col == CLW'(NT-1)) && (wcols >= ecols + 1))));
endmodule

bind ftnmf_recon ftnmf_recon_chk #(.NF(NF), .NT(NT), .RW(RW), .CLW(CLW)) chk_i (
   .clk(clk), .rst(rst), .in_valid(in_valid), .est_valid(est_valid),
   .est_row(est_row), .est_col(est_col));

// File: tb/ftnmf_recon_tb_top.sv
module ftnmf_recon_tb_top;
   localparam int NF = 8;
   localparam int NT = 6;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [9:0]  in_data = '0;
   logic [0:0]  in_cset = '0;
   logic        est_valid;
   logic [15:0] est_data;
   logic [2:0]  est_row;
   logic [2:0]  est_col;

   always #5 clk = ~clk;

   ftnmf_recon dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_cset(in_cset),
      .est_valid(est_valid), .est_data(est_data), .est_row(est_row), .est_col(est_col));

   typedef struct {
      int    row;
      int    col;
      int    val;
      string req;
   } exp_t;

   exp_t        q[$];
   int          checks = 0;
   int          errors = 0;
   int          popped = 0;
   bit          done = 1'b0;
   int          smp[NT][NF];
   int unsigned seed = 32'h1234_5678;

   // Weight sets as given in R2 (tap j = 3*(dt+1)+(df+1))
   int cf[2][9] = '{'{-60, 200, -60, 300, 1024, 300, -60, 200, -60},
                    '{-120, 350, -120, 450, 1024, 450, -120, 350, -120}};

   task automatic check(input bit ok, input string req, input int act, input int exp_v,
                        input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
      end
   endtask

   // Expected estimates of the frame held in smp (R2..R6)
   task automatic build_expect(input int set, input string base);
      for (int c = 0; c < NT; c++) begin
         for (int r = 0; r < NF; r++) begin
            int acc = 0;
            int v;
            bit sat = 1'b0;
            exp_t e;
            for (int dt = -1; dt <= 1; dt++) begin
               for (int df = -1; df <= 1; df++) begin
                  if (c + dt >= 0 && c + dt < NT && r + df >= 0 && r + df < NF)
                     acc += cf[set][3*(dt+1) + (df+1)] * smp[c+dt][r+df];
               end
            end
            v = (acc + 8) >>> 4;
            if (v > 32767)  begin v = 32767;  sat = 1'b1; end
            if (v < -32768) begin v = -32768; sat = 1'b1; end
            e.row = r;
            e.col = c;
            e.val = v;
            if (base != "")           e.req = base;
            else if (sat)             e.req = "R6";
            else if (r == 0 || r == NF-1) e.req = "R3";
            else if (c == 0 || c == NT-1) e.req = "R4";
            else                      e.req = "R2";
            q.push_back(e);
         end
      end
   endtask

   task automatic send_col(input int c, input int first_set, input int later_set);
      for (int r = 0; r < NF; r++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = 10'(smp[c][r]);
         in_cset  = (c == 0 && r == 0) ? 1'(first_set) : 1'(later_set);
         @(negedge clk);
         in_valid = 1'b0;
         repeat (8) @(negedge clk);
      end
   endtask

   task automatic send_frame(input int first_set, input int later_set);
      for (int c = 0; c < NT; c++) send_col(c, first_set, later_set);
   endtask

   function automatic int next_rand();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 16) & 32'd1023) - 512;
   endfunction

   // Monitor: pops an expectation for every estimate
   always @(negedge clk) begin
      if (!rst && est_valid) begin
         if (q.size() == 0) begin
            check(1'b0, "R9", 1, 0, "estimate with none pending");
         end else begin
            exp_t e;
            e = q.pop_front();
            popped++;
            check($signed(est_data) == e.val, e.req, $signed(est_data), e.val,
                  $sformatf("value at row %0d col %0d", e.row, e.col));
            check(int'(est_row) == e.row && int'(est_col) == e.col, "R7",
                  int'(est_row) * 100 + int'(est_col), e.row * 100 + e.col, "position tag");
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL R7 watchdog: actual %0d pending expected 0", q.size());
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check(est_valid == 1'b0, "R1", int'(est_valid), 0, "valid during reset");
      rst = 1'b0;
      repeat (3) @(negedge clk);
      check(est_valid == 1'b0, "R1", int'(est_valid), 0, "valid after reset");

      // Frame 1: pseudo-random samples, set 0 (R2, R3, R4)
      for (int c = 0; c < NT; c++)
         for (int r = 0; r < NF; r++) smp[c][r] = next_rand();
      build_expect(0, "");
      send_col(0, 0, 0);
      repeat (300) @(negedge clk);
      check(popped == 0, "R1", popped, 0, "estimates after first column only");
      for (int c = 1; c < NT; c++) send_col(c, 0, 0);

      // Frame 2: set 1 chosen at the start, code changes afterwards (R8)
      for (int c = 0; c < NT; c++)
         for (int r = 0; r < NF; r++) smp[c][r] = next_rand();
      build_expect(1, "R8");
      send_frame(1, 0);

      // Frame 3: full-scale positive, set 0 (R6)
      for (int c = 0; c < NT; c++)
         for (int r = 0; r < NF; r++) smp[c][r] = 511;
      build_expect(0, "");
      send_frame(0, 0);

      // Frame 4: full-scale negative, set 1 (R6, frame boundary R4)
      for (int c = 0; c < NT; c++)
         for (int r = 0; r < NF; r++) smp[c][r] = -512;
      build_expect(1, "");
      send_frame(1, 1);

      // Frame 5: sparse impulses producing half-way ties (R5)
      for (int c = 0; c < NT; c++)
         for (int r = 0; r < NF; r++) smp[c][r] = 0;
      smp[2][3] = 1;
      smp[4][5] = -2;
      build_expect(0, "R5");
      send_frame(0, 0);

      // Frame 6: all zero, first after a full-scale tail (R4 no leakage)
      for (int c = 0; c < NT; c++)
         for (int r = 0; r < NF; r++) smp[c][r] = 0;
      build_expect(0, "R4");
      send_frame(0, 0);

      for (int i = 0; i < 2000 && q.size() != 0; i++) @(negedge clk);
      repeat (100) @(negedge clk);
      check(q.size() == 0, "R9", q.size(), 0, "pending estimates at end");

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule